// File: doc/BRIEF.md
# FIFO Fill-Level Crossing Interrupt Generator

This block sits next to a pair of 16-entry serial-port FIFOs, one for receive and one for transmit. It watches each FIFO's fill count and its push or pop strobe. It raises a sticky raw status bit when the fill level moves across a threshold that software selects. Each threshold is a fixed fraction of the FIFO depth, in eighths. The block reacts to the crossing itself and not to the level. A FIFO that stays above or below its threshold never raises a status bit, and neither does a change of the threshold.

Software programs a small configuration register through a read/write port. The register has one 3-bit selector for each direction. Each direction has a detector built as a two-state machine. In `ST_QUIET` the status bit is low. The move `QUIET->FLAGGED` happens on a qualifying crossing, and the bit stays high in `ST_FLAGGED`. The move `FLAGGED->QUIET` happens on a write-one-to-clear pulse when no new crossing happens in the same cycle. The combined interrupt output is the OR of the two status bits.

Top module: `fifo_level_irq`

## Requirements
- R1: After an active-low reset, the configuration register reads 0x12, and `rx_ris`, `tx_ris` and `irq` are low.
- R2: The receive selector is register bits 5:3 and the transmit selector is bits 2:0. Both read back exactly as written. Bits 31:6 always read zero and ignore writes.
- R3: Selector codes 0, 1, 2, 3 and 4 choose threshold marks of 1/8, 1/4, 1/2, 3/4 and 7/8 of the depth. For the default depth of 16 these marks are fill counts 2, 4, 8, 12 and 14.
- R4: `rx_ris` sets on the clock edge where `rx_push` is high while `rx_count` equals the receive mark. The fill level then goes past the mark, so with the half mark the 9th character sets the bit.
- R5: A push that starts from any count other than the mark does not set `rx_ris`. This includes counts already beyond the mark.
- R6: `tx_ris` sets on the clock edge where `tx_pop` is high while `tx_count` equals the transmit mark plus one. The fill level then falls to the mark.
- R7: Codes 5, 6 and 7 are stored and read back, but no crossing is ever detected in that direction.
- R8: A status bit stays set until its clear input is pulsed. If a clear and a new crossing happen in the same cycle, the bit stays set.
- R9: Writing a selector never sets a status bit on its own, whatever the current fill count. Only a later strobe that crosses the new mark does.
- R10: `irq` equals `rx_ris` OR `tx_ris` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_count | input | 5 | Receive FIFO fill count before this cycle's push |
| rx_push | input | 1 | One entry is written into the receive FIFO this cycle |
| tx_count | input | 5 | Transmit FIFO fill count before this cycle's pop |
| tx_pop | input | 1 | One entry is read from the transmit FIFO this cycle |
| reg_wr | input | 1 | Write strobe for the configuration register |
| reg_wdata | input | 32 | Write data for the configuration register |
| reg_rdata | output | 32 | Current configuration register value |
| rx_clr | input | 1 | Write-one-to-clear for the receive status bit |
| tx_clr | input | 1 | Write-one-to-clear for the transmit status bit |
| rx_ris | output | 1 | Receive raw status bit |
| tx_ris | output | 1 | Transmit raw status bit |
| irq | output | 1 | OR of the two raw status bits |

## Verification
The hardest case to reach is a selector rewrite while the FIFO already sits beyond the new mark. It is followed by strobes that must stay silent until the count passes the new mark from below. To reach it, the bench fills the receive FIFO to ten entries and moves the mark below the current level and then above it. It then pushes across the mark. The bench also lines up a clear pulse with the exact crossing push, so that a clear and a set happen in the same cycle. A behavioural model compares every output on every clock while all of this runs.

// File: rtl/fifo_level_irq_pkg.sv
package fifo_level_irq_pkg;
    typedef enum logic {ST_QUIET = 1'b0, ST_FLAGGED = 1'b1} det_state_e;

    function automatic int mark_of(input int depth, input int code);
        case (code)
            0:       mark_of = depth / 8;
            1:       mark_of = depth / 4;
            2:       mark_of = depth / 2;
            3:       mark_of = (3 * depth) / 4;
            4:       mark_of = (7 * depth) / 8;
            default: mark_of = -1;
        endcase
    endfunction
endpackage

// File: rtl/fifo_level_cfg.sv
module fifo_level_cfg #(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [SEL_W-1:0]  rx_sel,
    output logic [SEL_W-1:0]  tx_sel
);
    localparam int USED_W = 2 * SEL_W;
    localparam logic [SEL_W-1:0] SEL_HALF = SEL_W'(2);

    logic [USED_W-1:0] cfg_q;
    logic unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:USED_W];

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= {SEL_HALF, SEL_HALF};
        else if (wr) cfg_q <= wdata[USED_W-1:0];
    end

    assign rx_sel = cfg_q[USED_W-1:SEL_W];
    assign tx_sel = cfg_q[SEL_W-1:0];
    assign rdata  = {{(DATA_W-USED_W){1'b0}}, cfg_q};

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(rdata));
endmodule

// File: rtl/fifo_level_mark.sv
module fifo_level_mark
    import fifo_level_irq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SEL_W = 3,
    parameter int CNT_W = 5
) (
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] mark,
    output logic             mark_ok
);
    int m;
    always_comb begin
        m       = mark_of(DEPTH, int'(sel));
        mark_ok = (m >= 0);
        mark    = mark_ok ? m[CNT_W-1:0] : '0;
    end
endmodule

// File: rtl/fifo_cross_det.sv
module fifo_cross_det
    import fifo_level_irq_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter bit FALLING = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] mark,
    input  logic             mark_ok,
    input  logic             clr,
    output logic             ris
);
    det_state_e state_q, state_d;
    logic hit;

    generate
        if (FALLING) begin : g_fall
            assign hit = strobe && mark_ok && (count == mark + CNT_W'(1));
        end else begin : g_rise
            assign hit = strobe && mark_ok && (count == mark);
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:   if (hit) state_d = ST_FLAGGED;
            ST_FLAGGED: if (clr && !hit) state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        ris = (state_q == ST_FLAGGED);
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ris);
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ris && !clr |=> ris);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ris && clr && !hit |=> !ris);
    p_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ris) |-> $past(strobe));
endmodule

// File: rtl/fifo_level_irq.sv
module fifo_level_irq #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 3,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              rx_push,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic              tx_pop,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rx_clr,
    input  logic              tx_clr,
    output logic              rx_ris,
    output logic              tx_ris,
    output logic              irq
);
    localparam int NDIR = 2;

    logic [SEL_W-1:0] sel  [NDIR];
    logic [CNT_W-1:0] mark [NDIR];
    logic [CNT_W-1:0] cnt  [NDIR];
    logic             ok   [NDIR];
    logic             stb  [NDIR];
    logic             clr  [NDIR];
    logic             ris  [NDIR];

    fifo_level_cfg #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
        .rdata(reg_rdata), .rx_sel(sel[0]), .tx_sel(sel[1])
    );

    assign cnt[0] = rx_count;  assign stb[0] = rx_push; assign clr[0] = rx_clr;
    assign cnt[1] = tx_count;  assign stb[1] = tx_pop;  assign clr[1] = tx_clr;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        fifo_level_mark #(.DEPTH(DEPTH), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_mark (
            .sel(sel[d]), .mark(mark[d]), .mark_ok(ok[d])
        );
        fifo_cross_det #(.CNT_W(CNT_W), .FALLING(d == 1)) u_det (
            .clk(clk), .rst_n(rst_n), .strobe(stb[d]), .count(cnt[d]),
            .mark(mark[d]), .mark_ok(ok[d]), .clr(clr[d]), .ris(ris[d])
        );
    end

    assign rx_ris = ris[0];
    assign tx_ris = ris[1];
    assign irq    = rx_ris | tx_ris;

    p_quiet_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[5:3] > 3'd4) && !rx_ris |=> !rx_ris);
endmodule

// File: tb/fifo_level_irq_bench.sv
module fifo_level_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rx_count = '0, tx_count = '0;
    logic        rx_push = 0, tx_pop = 0, reg_wr = 0, rx_clr = 0, tx_clr = 0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        rx_ris, tx_ris, irq;

    int checks = 0, failures = 0;
    int m_rx = 0, m_tx = 0;
    int m_cfg = 'h12;
    bit e_rx = 0, e_tx = 0, done = 0;

    always #5 clk = ~clk;

    fifo_level_irq u_fifo_level_irq (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .rx_push(rx_push),
        .tx_count(tx_count), .tx_pop(tx_pop), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_clr(rx_clr),
        .tx_clr(tx_clr), .rx_ris(rx_ris), .tx_ris(tx_ris), .irq(irq)
    );

    function automatic int thr(input int code);
        if (code > 4) return -1;
        return (code == 0) ? 2 : (code == 1) ? 4 : (code == 2) ? 8 : (code == 3) ? 12 : 14;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare(input string req);
        chk({req, " rx_ris"}, rx_ris, e_rx);
        chk({req, " tx_ris"}, tx_ris, e_tx);
        chk("R10 irq", irq, e_rx | e_tx);
        chk("R2 readback", reg_rdata, m_cfg);
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input string req, input bit push, input bit pop,
                        input bit rc, input bit tc, input bit wr, input int wd);
        rx_count = 5'(m_rx); tx_count = 5'(m_tx);
        rx_push = push; tx_pop = pop; rx_clr = rc; tx_clr = tc;
        reg_wr = wr; reg_wdata = wd;
        @(posedge clk);
        e_rx = (e_rx && !rc) || (push && thr((m_cfg >> 3) & 7) >= 0 && m_rx == thr((m_cfg >> 3) & 7));
        e_tx = (e_tx && !tc) || (pop && thr(m_cfg & 7) >= 0 && m_tx == thr(m_cfg & 7) + 1);
        if (wr) m_cfg = wd & 'h3f;
        if (push) m_rx++;
        if (pop) m_tx--;
        @(negedge clk);
        rx_push = 0; tx_pop = 0; rx_clr = 0; tx_clr = 0; reg_wr = 0;
        compare(req);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");
        // R4: default half mark, ninth push sets
        for (int i = 0; i < 16; i++) begin
            step("R4 rx fill", 1, 0, 0, 0, 0, 0);
            if (i == 7) chk("R4 not yet at 8", rx_ris, 0);
            if (i == 8) chk("R4 ninth char", rx_ris, 1);
        end
        step("R8 hold", 0, 0, 0, 0, 0, 0);
        step("R8 clear", 0, 0, 1, 0, 0, 0);
        chk("R8 cleared", rx_ris, 0);
        // R3 sweep of valid codes, R5 no set beyond mark
        for (int c = 0; c < 5; c++) begin
            m_rx = 0;
            step("R3 write", 0, 0, 0, 0, 1, (c << 3) | 2);
            for (int i = 0; i < 16; i++) step("R3 sweep", 1, 0, 0, 0, 0, 0);
            chk("R5 set once", rx_ris, 1);
            step("R3 clr", 0, 0, 1, 0, 0, 0);
        end
        // R7 reserved codes
        for (int c = 5; c < 8; c++) begin
            m_rx = 0;
            step("R7 write", 0, 0, 0, 0, 1, (c << 3) | c);
            chk("R7 stored", reg_rdata[5:3], c);
            m_tx = 16;
            for (int i = 0; i < 16; i++) step("R7 silent", 1, 1, 0, 0, 0, 0);
            chk("R7 rx quiet", rx_ris, 0);
            chk("R7 tx quiet", tx_ris, 0);
        end
        // R6 transmit falling crossing
        step("R2 wr", 0, 0, 0, 0, 1, 'hFFFF_FFC0 | (2 << 3) | 2);
        chk("R2 hi zero", reg_rdata, 'h12);
        m_tx = 16;
        for (int i = 0; i < 16; i++) begin
            step("R6 drain", 0, 1, 0, 0, 0, 0);
            if (i == 7) chk("R6 at 8", tx_ris, 1);
        end
        step("R6 clr", 0, 0, 0, 1, 0, 0);
        // R8 clear coinciding with crossing
        m_tx = 9;
        step("R8 pre", 0, 0, 0, 0, 0, 0);
        m_rx = 8;
        step("R8 rx cross", 1, 0, 0, 0, 0, 0);
        step("R8 rx clr+cross", 0, 0, 1, 0, 0, 0);
        m_rx = 8;
        step("R8 set", 1, 0, 0, 0, 0, 0);
        m_rx = 8;
        step("R8 clr+set", 1, 1, 1, 1, 0, 0);
        chk("R8 rx stays", rx_ris, 1);
        chk("R8 tx stays", tx_ris, 1);
        step("R8 clr both", 0, 0, 1, 1, 0, 0);
        // R9 level change with data present
        m_rx = 10;
        step("R9 to 1/8", 0, 0, 0, 0, 1, (0 << 3) | 2);
        step("R9 push past", 1, 0, 0, 0, 0, 0);
        chk("R9 no set low", rx_ris, 0);
        step("R9 to 3/4", 0, 0, 0, 0, 1, (3 << 3) | 2);
        step("R9 11->12", 1, 0, 0, 0, 0, 0);
        chk("R9 no set at mark", rx_ris, 0);
        step("R9 12->13", 1, 0, 0, 0, 0, 0);
        chk("R9 set on cross", rx_ris, 1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule